// File: doc/BRIEF.md
# Dual Trigger Event Capture

This block watches two asynchronous external trigger lines. Each line is brought into the system clock domain through a short flop chain, and its settled level is reported in an 8-bit status word. Any change of level, rising or falling, raises a sticky per-trigger pending flag that stays set until the consumer acknowledges it.

When the first flag of an empty set is raised, the block copies a 64-bit free-running time base into a stamp register. This is the same counter that stamps video frames, so a trigger can be matched to a frame. A downstream buffer reads the status word and the stamp while the event-valid flag is high, then pulses the acknowledge strobe.

The status word always carries both the levels and the flags. A consumer polling the levels directly uses the level bits. A consumer fed by the event buffer uses the pending bits.

Top module: `trig_capture`

## Requirements
- R1: After reset, `activity_o`, `stamp_o` and `evt_valid_o` are all zero, and the time base restarts at 0.
- R2: `activity_o[5]` shows trigger 0 and `activity_o[6]` shows trigger 1. A change on `trig_i` appears after the second rising clock edge following it, and not after the first.
- R3: Any level change (rise or fall) on a trigger sets its pending bit one clock after the level bit changes. Trigger 0 uses `activity_o[1]` and trigger 1 uses `activity_o[2]`. With no change, no pending bit is set.
- R4: A pending bit stays set until `ack_i` is high at a clock edge. That edge clears both pending bits.
- R5: A level change whose pending bit would be set at the same edge as an acknowledge wins: that bit ends set, and the stamp is captured anew.
- R6: Bits 0, 3, 4 and 7 of `activity_o` are always zero.
- R7: The time base is 0 after reset and adds one at every clock edge. `stamp_o` takes the time-base value present just before the edge that sets a pending bit while none was pending. For a trigger change driven when the time base reads T, the stamp is T+2.
- R8: While any bit is pending and no acknowledge arrives, `stamp_o` does not change, even if the other trigger produces an event.
- R9: `evt_valid_o` is high exactly when at least one pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 2 | Asynchronous trigger lines, bit 0 is trigger 0 |
| ack_i | input | 1 | Read/acknowledge strobe, clears pending flags |
| activity_o | output | 8 | Status word: levels in bits 5/6, pending flags in bits 1/2 |
| stamp_o | output | 64 | Time-base value captured at the first pending event |
| evt_valid_o | output | 1 | At least one event is pending |

## Verification
The bench sweeps every toggle pattern (trigger 0, trigger 1, both) from each reachable level state, in both rising and falling directions.

At each event it checks the exact edge where the level bit, the pending bit and the stamp move. A design with one synchronizer flop too few or too many shows the level a cycle off. A design that detects only rising edges misses every second event.

It drives a second event while the first is still pending. A design that overwrites the stamp there loses the time of the first trigger. It also drives an acknowledge into the same edge as a fresh event. A design that gives the clear priority drops that event, and one that skips recapture reports a stale time.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int unsigned NUM_TRIG = 2;
  localparam int unsigned ACT_W    = 8;
  localparam int unsigned PEND_LSB = 1;
  localparam int unsigned LVL_LSB  = 5;
  typedef logic [NUM_TRIG-1:0] trig_vec_t;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= '0;
    else         chain_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/trig_timebase.sv
module trig_timebase #(
  parameter int unsigned TS_W = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [TS_W-1:0] count_o
);
  logic [TS_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;
endmodule

// File: rtl/trig_pend.sv
module trig_pend #(
  parameter int unsigned WIDTH = 2,
  parameter int unsigned TS_W  = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] level_i,
  input  logic             ack_i,
  input  logic [TS_W-1:0]  time_i,
  output logic [WIDTH-1:0] pend_o,
  output logic [TS_W-1:0]  stamp_o
);
  logic [WIDTH-1:0] prev_q, pend_q, edge_w, pend_d;
  logic [TS_W-1:0]  stamp_q;
  logic             capture_w;

  assign edge_w    = level_i ^ prev_q;
  // set beats clear
  assign pend_d    = edge_w | (pend_q & {WIDTH{~ack_i}});
  // new stamp only when the set was empty or is being emptied
  assign capture_w = (|edge_w) & ((pend_q == '0) | ack_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      pend_q  <= '0;
      stamp_q <= '0;
    end else begin
      prev_q <= level_i;
      pend_q <= pend_d;
      if (capture_w) stamp_q <= time_i;
    end
  end

  assign pend_o  = pend_q;
  assign stamp_o = stamp_q;
endmodule

// File: rtl/trig_capture.sv
module trig_capture
  import trig_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TS_W        = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic                ack_i,
  output logic [ACT_W-1:0]    activity_o,
  output logic [TS_W-1:0]     stamp_o,
  output logic                evt_valid_o
);
  trig_vec_t       level_w, pend_w;
  logic [TS_W-1:0] time_w;

  trig_sync #(.WIDTH(NUM_TRIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(trig_i), .sync_o(level_w)
  );

  trig_timebase #(.TS_W(TS_W)) u_tb (
    .clk_i(clk_i), .rst_ni(rst_ni), .count_o(time_w)
  );

  trig_pend #(.WIDTH(NUM_TRIG), .TS_W(TS_W)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(level_w), .ack_i(ack_i),
    .time_i(time_w), .pend_o(pend_w), .stamp_o(stamp_o)
  );

  always_comb begin
    activity_o = '0;
    for (int k = 0; k < NUM_TRIG; k++) begin
      activity_o[PEND_LSB+k] = pend_w[k];
      activity_o[LVL_LSB+k]  = level_w[k];
    end
  end

  assign evt_valid_o = |pend_w;
endmodule

// File: rtl/trig_capture_chk.sv
module trig_capture_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ack_i,
  input logic [7:0]  activity_o,
  input logic [63:0] stamp_o,
  input logic        evt_valid_o
);
  a_r6_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (activity_o[0] | activity_o[3] | activity_o[4] | activity_o[7]) == 1'b0);

  a_r9_valid_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o == (activity_o[1] | activity_o[2]));

  a_r3_change0_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(activity_o[5]) |=> activity_o[1]);

  a_r3_change1_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(activity_o[6]) |=> activity_o[2]);

  a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && !ack_i) |=> evt_valid_o);

  a_r4_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && $stable(activity_o[6:5])) |=> !evt_valid_o);

  a_r8_stamp_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && !ack_i) |=> $stable(stamp_o));
endmodule

bind trig_capture trig_capture_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack_i), .activity_o(activity_o),
  .stamp_o(stamp_o), .evt_valid_o(evt_valid_o)
);

// File: tb/trig_capture_tb_top.sv
module trig_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  trig = 2'b00;
  logic        ack = 1'b0;
  logic [7:0]  act;
  logic [63:0] stamp;
  logic        evt;
  logic [63:0] cyc;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  trig_capture dut_i (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .ack_i(ack),
    .activity_o(act), .stamp_o(stamp), .evt_valid_o(evt)
  );

  // time base model: 0 in reset, +1 per edge
  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_ack();
    ack = 1'b1; step(1); ack = 1'b0;
  endtask

  function automatic logic [7:0] exp_act(input logic [1:0] lvl, input logic [1:0] pnd);
    return {1'b0, lvl, 2'b00, pnd, 1'b0};
  endfunction

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] t0;
    logic [1:0]  old;
    step(2);
    check("R1 activity", act, 0);
    check("R1 stamp", stamp, 0);
    check("R1 valid", evt, 0);
    rst_n = 1'b1;
    step(5);
    check("R3 no change no pending", act, 0);
    check("R1 time base restart", cyc, 5);

    for (int rep = 0; rep < 2; rep++) begin
      for (int pat = 1; pat < 4; pat++) begin
        old = trig;
        t0 = cyc;
        trig = trig ^ pat[1:0];
        step(1);
        check("R2 not after one edge", act, exp_act(old, 2'b00));
        step(1);
        check("R2 level after two edges", act, exp_act(trig, 2'b00));
        step(1);
        check("R3 pending set", act, exp_act(trig, pat[1:0]));
        check("R9 valid high", evt, 1);
        check("R7 stamp", stamp, t0 + 2);
        if (pat != 3) begin
          trig = trig ^ (~pat[1:0]);
          step(3);
          check("R8 both pending", act, exp_act(trig, 2'b11));
          check("R8 stamp held", stamp, t0 + 2);
        end
        step(2);
        check("R4 sticky", evt, 1);
        do_ack();
        check("R4 ack clears", act, exp_act(trig, 2'b00));
        check("R9 valid low", evt, 0);
        check("R6 unused bits", act & 8'h99, 0);
      end
    end

    // R5: fresh event meets acknowledge at the same edge
    trig = trig ^ 2'b10;
    step(4);
    check("R5 setup pending1", act[2:1], 2'b10);
    t0 = cyc;
    trig = trig ^ 2'b01;
    step(2);
    do_ack();
    check("R5 event wins", act, exp_act(trig, 2'b01));
    check("R5 stamp recaptured", stamp, t0 + 2);
    do_ack();
    check("R4 idle ack", act, exp_act(trig, 2'b00));
    do_ack();
    check("R4 ack on empty", evt, 0);
    check("R7 stamp kept after clear", stamp, t0 + 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule